// File: doc/BRIEF.md
# PWM Pin Level Controller

This block owns the level of a single PWM output pin belonging to one channel of a 16-bit timer. The counter logic around it reports events as one-cycle strobes: the count reached the compare value, the count reached the period value, the counter was started, the counter was stopped. For each strobe the block applies a configured action to a stored pin level. The pad side gets a level together with a drive-enable flag. When that flag is low the pad floats.

Each match event has its own 2-bit action: drive low, drive high, keep the level, or invert it. Start and stop can either load a configured one-bit level or leave the pin untouched. A brake input overrides the pin with a safe state chosen from four codes, one of which floats the pad. The stored level keeps following events while brake is active. When brake is released, the pin therefore shows the level the events have produced. The pad is never driven while the pin is configured as a capture input, and never while the output-enable bit is clear.

Top module: `pwm_pin_ctrl`

## Requirements
- R1: Compare-match action codes: 0 sets the level low, 1 sets it high, 2 keeps it, 3 inverts it. The new level shows on `pin_o` after the clock edge that samples `cmp_hit_i`.
- R2: A period match applies `prd_act_i` with the same four codes, independently of `cmp_act_i`.
- R3: When compare match and period match fall in the same cycle, only the period-match action is applied.
- R4: With `runctl_hold_i` = 0, a start strobe loads `start_lvl_i` and a stop strobe loads `stop_lvl_i` (0 = low, 1 = high). If both strobes arrive in the same cycle, the stop level wins.
- R5: With `runctl_hold_i` = 1, start and stop strobes leave the level unchanged.
- R6: A start or stop strobe takes precedence over any match strobe in the same cycle.
- R7: While `brake_i` = 1 and the pad is otherwise driven, `brake_mode_i` selects the pad state combinationally: 0 shows the stored level with `pin_oe_o` = 1; 1 gives `pin_oe_o` = 0; 2 forces `pin_o` = 0; 3 forces `pin_o` = 1. Codes 2 and 3 both keep `pin_oe_o` = 1.
- R8: Events keep updating the stored level during brake. After brake is released, `pin_o` shows that updated level.
- R9: With `capture_mode_i` = 1, `pin_oe_o` = 0 and `pin_o` = 0.
- R10: With `out_en_i` = 0, `pin_oe_o` = 0 and `pin_o` = 0, whatever the brake state. The stored level is not lost.
- R11: Reset (asynchronous, active low) clears the stored level to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_hit_i | input | 1 | Compare-match strobe |
| prd_hit_i | input | 1 | Period-match strobe |
| cnt_start_i | input | 1 | Counter start strobe |
| cnt_stop_i | input | 1 | Counter stop strobe |
| cmp_act_i | input | 2 | Compare-match action code |
| prd_act_i | input | 2 | Period-match action code |
| runctl_hold_i | input | 1 | 1: start/stop keep the level; 0: start/stop load a level |
| start_lvl_i | input | 1 | Level loaded on start |
| stop_lvl_i | input | 1 | Level loaded on stop |
| brake_i | input | 1 | Brake request |
| brake_mode_i | input | 2 | Brake pad state code |
| out_en_i | input | 1 | Output driver enable |
| capture_mode_i | input | 1 | Pin is used as a capture input |
| pin_o | output | 1 | Pin level toward the pad |
| pin_oe_o | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
The bench targets the collisions between events. These cases are checked:
- Compare and period strobes in the same cycle with opposing actions. A wrong priority shows the compare result instead.
- Start or stop strobes alongside match strobes. A design that lets a match win there leaves the wrong level.
- Start and stop in the same cycle, where the stop level must win.
- Invert actions applied twice in a row, which catch a toggle that is taken from the wrong level.

Brake is checked in all four codes. Events are applied during brake and then brake is released, which exposes a design that freezes the stored level or latches the brake value into it. The tests also show that the capture and disable gates dominate brake, and that disabling the driver does not corrupt the stored level.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;
  localparam int ACT_W = 2;
  localparam int BRK_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_LOW  = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_KEEP = 2'd2,
    ACT_INV  = 2'd3
  } act_e;

  typedef enum logic [BRK_W-1:0] {
    BRK_RUN   = 2'd0,
    BRK_FLOAT = 2'd1,
    BRK_LOW   = 2'd2,
    BRK_HIGH  = 2'd3
  } brk_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_RUNCTL = 2'd1,
    SRC_PRD    = 2'd2,
    SRC_CMP    = 2'd3
  } src_e;

  function automatic logic apply_act(act_e act, logic cur);
    case (act)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_INV:  return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_evt_arb.sv
module pwm_evt_arb
  import pwm_pin_pkg::*;
(
  input  logic cmp_hit_i,
  input  logic prd_hit_i,
  input  logic cnt_start_i,
  input  logic cnt_stop_i,
  input  act_e cmp_act_i,
  input  act_e prd_act_i,
  input  logic runctl_hold_i,
  input  logic start_lvl_i,
  input  logic stop_lvl_i,
  output act_e act_o,
  output src_e src_o
);
  logic runctl_lvl;

  // stop outranks start when both strobe together
  assign runctl_lvl = cnt_stop_i ? stop_lvl_i : start_lvl_i;

  always_comb begin
    if (cnt_start_i || cnt_stop_i) begin
      src_o = SRC_RUNCTL;
      if (runctl_hold_i) act_o = ACT_KEEP;
      else               act_o = runctl_lvl ? ACT_HIGH : ACT_LOW;
    end else if (prd_hit_i) begin
      src_o = SRC_PRD;
      act_o = prd_act_i;
    end else if (cmp_hit_i) begin
      src_o = SRC_CMP;
      act_o = cmp_act_i;
    end else begin
      src_o = SRC_NONE;
      act_o = ACT_KEEP;
    end
  end
endmodule

// File: rtl/pwm_lvl_reg.sv
module pwm_lvl_reg
  import pwm_pin_pkg::*;
#(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  act_e act_i,
  output logic lvl_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= RST_LVL;
    else         lvl_q <= apply_act(act_i, lvl_q);
  end

  assign lvl_o = lvl_q;

  AST_KEEP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_KEEP |=> $stable(lvl_q)); // R1
  AST_INV_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_INV |=> lvl_q != $past(lvl_q)); // R1
endmodule

// File: rtl/pwm_pad_stage.sv
module pwm_pad_stage
  import pwm_pin_pkg::*;
(
  input  logic lvl_i,
  input  logic brake_i,
  input  brk_e brake_mode_i,
  input  logic out_en_i,
  input  logic capture_mode_i,
  output logic pin_o,
  output logic pin_oe_o
);
  logic drive_ok;

  assign drive_ok = out_en_i && !capture_mode_i;

  always_comb begin
    pin_o    = 1'b0;
    pin_oe_o = 1'b0;
    if (drive_ok) begin
      pin_oe_o = 1'b1;
      pin_o    = lvl_i;
      if (brake_i) begin
        case (brake_mode_i)
          BRK_FLOAT: begin pin_oe_o = 1'b0; pin_o = 1'b0; end
          BRK_LOW:   pin_o = 1'b0;
          BRK_HIGH:  pin_o = 1'b1;
          default:   pin_o = lvl_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_pin_ctrl.sv
module pwm_pin_ctrl
  import pwm_pin_pkg::*;
#(
  parameter logic RST_LVL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_hit_i,
  input  logic             prd_hit_i,
  input  logic             cnt_start_i,
  input  logic             cnt_stop_i,
  input  logic [ACT_W-1:0] cmp_act_i,
  input  logic [ACT_W-1:0] prd_act_i,
  input  logic             runctl_hold_i,
  input  logic             start_lvl_i,
  input  logic             stop_lvl_i,
  input  logic             brake_i,
  input  logic [BRK_W-1:0] brake_mode_i,
  input  logic             out_en_i,
  input  logic             capture_mode_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  act_e act;
  src_e src;
  logic lvl;

  pwm_evt_arb u_arb (
    .cmp_hit_i     (cmp_hit_i),
    .prd_hit_i     (prd_hit_i),
    .cnt_start_i   (cnt_start_i),
    .cnt_stop_i    (cnt_stop_i),
    .cmp_act_i     (act_e'(cmp_act_i)),
    .prd_act_i     (act_e'(prd_act_i)),
    .runctl_hold_i (runctl_hold_i),
    .start_lvl_i   (start_lvl_i),
    .stop_lvl_i    (stop_lvl_i),
    .act_o         (act),
    .src_o         (src)
  );

  pwm_lvl_reg #(.RST_LVL(RST_LVL)) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .lvl_o  (lvl)
  );

  pwm_pad_stage u_pad (
    .lvl_i          (lvl),
    .brake_i        (brake_i),
    .brake_mode_i   (brk_e'(brake_mode_i)),
    .out_en_i       (out_en_i),
    .capture_mode_i (capture_mode_i),
    .pin_o          (pin_o),
    .pin_oe_o       (pin_oe_o)
  );

  AST_RUNCTL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_start_i || cnt_stop_i) |-> src == SRC_RUNCTL); // R6
  AST_PRD_OVER_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_hit_i && cmp_hit_i && !cnt_start_i && !cnt_stop_i && prd_act_i == 2'd1) |=> lvl); // R3
  AST_RUNCTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_start_i || cnt_stop_i) && runctl_hold_i) |=> $stable(lvl)); // R5
  AST_CAPTURE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_mode_i |-> !pin_oe_o); // R9
  AST_BRAKE_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brake_i && brake_mode_i == 2'd1) |-> !pin_oe_o); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> (!pin_oe_o && !pin_o)); // R10
endmodule

// File: tb/pwm_pin_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_pin_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_hit = 0, prd_hit = 0, cnt_start = 0, cnt_stop = 0;
  logic [1:0] cmp_act = 0, prd_act = 0, brake_mode = 0;
  logic hold = 0, start_lvl = 0, stop_lvl = 0, brake = 0;
  logic out_en = 1, cap_mode = 0;
  logic pin, pin_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_pin_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_hit_i(cmp_hit), .prd_hit_i(prd_hit),
    .cnt_start_i(cnt_start), .cnt_stop_i(cnt_stop), .cmp_act_i(cmp_act),
    .prd_act_i(prd_act), .runctl_hold_i(hold), .start_lvl_i(start_lvl),
    .stop_lvl_i(stop_lvl), .brake_i(brake), .brake_mode_i(brake_mode),
    .out_en_i(out_en), .capture_mode_i(cap_mode), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  // {cmp,prd,start,stop,hold,start_lvl,stop_lvl,cmp_act,prd_act,brake,brake_mode,exp_pin,exp_oe}
  localparam int NV = 27;
  localparam logic [15:0] VEC [NV] = '{
    {7'b0000000, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R11 idle after reset
    {7'b1000000, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}, // R1 high
    {7'b1000000, 2'd2, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}, // R1 keep
    {7'b1000000, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R1 invert
    {7'b1000000, 2'd3, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}, // R1 invert
    {7'b1000000, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R1 low
    {7'b0100000, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1}, // R2 high
    {7'b0100000, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1}, // R2 invert
    {7'b1100000, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1}, // R3 period wins
    {7'b1100000, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R3 period wins
    {7'b0010010, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}, // R4 start level
    {7'b0001000, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R4 stop level
    {7'b0110010, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}, // R6 start over period
    {7'b1001000, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R6 stop over compare
    {7'b0011010, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R4 stop beats start
    {7'b0010110, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R5 start holds
    {7'b0100000, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1}, // R2 high
    {7'b0001100, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}, // R5 stop holds
    {7'b0100000, 2'd0, 2'd2, 1'b0, 2'd0, 1'b1, 1'b1}, // R2 keep
    {7'b0100000, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1}, // R2 low, cmp action ignored
    {7'b0000000, 2'd0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0}, // R7 float
    {7'b1000000, 2'd3, 2'd0, 1'b1, 2'd2, 1'b0, 1'b1}, // R8 lvl->1 under forced low
    {7'b0000000, 2'd0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1}, // R7 code 0 shows level
    {7'b1000000, 2'd3, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1}, // R8 lvl->0 under forced high
    {7'b0000000, 2'd0, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1}, // R7 forced high
    {7'b1000000, 2'd1, 2'd0, 1'b1, 2'd2, 1'b0, 1'b1}, // R8 lvl->1 under forced low
    {7'b0000000, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1}  // R8 release shows level
  };

  task automatic check(string req, logic ep, logic eo);
    n_chk++;
    if (pin !== ep || pin_oe !== eo) begin
      n_fail++;
      $display("FAIL %s: pin=%b oe=%b expected pin=%b oe=%b", req, pin, pin_oe, ep, eo);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", 1'b0, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cmp_hit, prd_hit, cnt_start, cnt_stop, hold, start_lvl, stop_lvl} = VEC[i][15:9];
      cmp_act = VEC[i][8:7];
      prd_act = VEC[i][6:5];
      brake = VEC[i][4];
      brake_mode = VEC[i][3:2];
      @(posedge clk); #1;
      check($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
    end
    @(negedge clk);
    {cmp_hit, prd_hit, cnt_start, cnt_stop, hold, brake} = '0;
    cap_mode = 1'b1; #1;
    check("R9 capture", 1'b0, 1'b0);
    cap_mode = 1'b0; #1;
    check("R9 back to drive", 1'b1, 1'b1);
    out_en = 1'b0; #1;
    check("R10 disabled", 1'b0, 1'b0);
    brake = 1'b1; brake_mode = 2'd3; #1;
    check("R10 disabled beats brake", 1'b0, 1'b0);
    brake = 1'b0;
    @(negedge clk);
    out_en = 1'b1; #1;
    check("R10 level kept", 1'b1, 1'b1);
    rst_n = 1'b0; #1;
    check("R11 async reset", 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule